// File: doc/BRIEF.md
# SDLC Receive Buffer DMA Manager

This block places the information field of an incoming synchronous data-link frame into a byte-addressed on-chip RAM. A deserializer upstream hands it one byte at a time with four strobes: frame start, control byte valid, data byte valid and frame end. The block captures the control byte into its own register. It writes each information byte to RAM, starting at an address the CPU programs. Along the way it counts the bytes stored and the buffer space still free.

The CPU programs a start address and a buffer length, then sets the receive-enable bit. A frame start that arrives while receive-enable is high opens a frame. Reception closes when the programmed space runs out, when the RAM ceiling at address 191 is reached, or when the frame ends. Each of these clears receive-enable, so the CPU can then read the received length and the control byte safely. The write address never wraps. Bytes that arrive after the buffer end are dropped and flagged as an overrun.

Top module: `sdlc_rxbuf_dma`

## Requirements
- R1: After reset, receive-enable, buffer-end, overrun, frame-done and RAM write-enable are all low, and the start address, buffer length, received length, control byte and remaining count all read zero.
- R2: A CPU write to the start address or the buffer length takes effect on the next clock only when receive-enable is low. Such writes are ignored while receive-enable is high. Bit 0 of the write data on an enable write becomes the receive-enable bit.
- R3: A frame-start strobe is accepted only while receive-enable is high. Accepting it loads the remaining count from the buffer length, loads the write pointer from the start address, clears the received-byte counter, clears overrun and clears buffer-end. A frame-start strobe while receive-enable is low has no effect.
- R4: Each data byte accepted during an open frame produces, on the next clock, a one-cycle RAM write. The write address equals the start address plus the number of bytes already stored, and the remaining count drops by one.
- R5: When the remaining count reaches zero, buffer-end is raised and receive-enable is cleared. A zero buffer length raises buffer-end at frame start. Later data bytes produce no RAM write.
- R6: A RAM write at address 191 raises buffer-end whatever space remains. No write ever goes above 191. A start address above 191 raises buffer-end at frame start with no write.
- R7: A data byte that arrives after buffer-end and before frame end sets the overrun flag. The flag stays set until the next accepted frame start.
- R8: A frame-end strobe during an open frame loads the received length with the number of bytes stored, produces a one-cycle frame-done pulse and clears receive-enable.
- R9: A control-valid strobe during an open frame captures the byte into the control register. Outside an open frame the strobe is ignored.
- R10: The remaining count is visible on an output at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_start | input | 1 | CPU write strobe, start address |
| cpu_wr_len | input | 1 | CPU write strobe, buffer length |
| cpu_wr_enable | input | 1 | CPU write strobe, receive-enable (bit 0 of data) |
| cpu_wdata | input | 8 | CPU write data |
| rx_sof | input | 1 | Frame start strobe |
| rx_ctl_vld | input | 1 | Control byte valid |
| rx_dat_vld | input | 1 | Information byte valid |
| rx_eof | input | 1 | Frame end strobe |
| rx_byte | input | 8 | Byte from the deserializer |
| start_addr_o | output | 8 | Programmed start address |
| buf_len_o | output | 8 | Programmed buffer length |
| rx_len_o | output | 8 | Information bytes stored in the last frame |
| ctrl_byte_o | output | 8 | Captured control byte |
| remain_o | output | 8 | Buffer bytes still free |
| rx_en_o | output | 1 | Receive-enable bit |
| buf_end_o | output | 1 | Buffer end reached |
| overrun_o | output | 1 | Data arrived after buffer end |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |

## Verification
On every cycle the assertions check four things. Writes never go above the ceiling, and each write lowers the remaining count by exactly one. The buffer length holds while receive-enable is high, and overrun is only seen together with buffer-end. They also check that frame-done lasts one cycle and that a rising buffer-end leaves receive-enable low. Only the bench scenarios can show the rest, because that needs a whole frame as context. That covers the addresses and data of each write, the received length at frame end, and the zero-length, ceiling and out-of-range start-address cases. It also covers the clearing of overrun by a later frame and the dropping of strobes while no frame is open.

// File: rtl/sdlc_rxbuf_pkg.sv
package sdlc_rxbuf_pkg;

    localparam int BYTE_W        = 8;
    localparam int ADDR_CEIL_DEF = 191;

    // One beat of the deserializer interface, packed for the engine
    typedef struct packed {
        logic              sof;
        logic              ctl;
        logic              dat;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

endpackage

// File: rtl/sdlc_rxbuf_regs.sv
module sdlc_rxbuf_regs #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_len,
    input  logic              wr_enable,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en_clear,
    output logic [ADDR_W-1:0] start_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              rx_en
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  len;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // configuration is frozen while reception is armed
        if (wr_start && !cfg_q.en) cfg_d.start = wdata[ADDR_W-1:0];
        if (wr_len && !cfg_q.en)   cfg_d.len   = wdata[LEN_W-1:0];
        if (wr_enable)             cfg_d.en    = wdata[0];
        // a closing frame or buffer end wins over a CPU set
        if (en_clear)              cfg_d.en    = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_addr = cfg_q.start;
    assign buf_len    = cfg_q.len;
    assign rx_en      = cfg_q.en;

    // R2
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q.en) |-> $stable(cfg_q.len));

    // R2
    start_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q.en) |-> $stable(cfg_q.start));

endmodule

// File: rtl/sdlc_rxbuf_engine.sv
module sdlc_rxbuf_engine
    import sdlc_rxbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int ADDR_CEIL = ADDR_CEIL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_beat_t          beat,
    input  logic              rx_en,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  buf_len,
    output logic              en_clear,
    output logic [LEN_W-1:0]  rx_len,
    output logic [BYTE_W-1:0] ctrl_byte,
    output logic [LEN_W-1:0]  remain,
    output logic              buf_end,
    output logic              overrun,
    output logic              frame_done,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);

    localparam logic [ADDR_W-1:0] CEIL_A  = ADDR_W'(ADDR_CEIL);
    localparam logic [LEN_W-1:0]  LEN_ONE = LEN_W'(1);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  rxlen;
        logic [BYTE_W-1:0] ctrl;
        logic              bend;
        logic              ovr;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [BYTE_W-1:0] wdata;
    } eng_t;

    eng_t st_d, st_q;
    logic clr_d;
    logic last_slot;

    // the slot about to be written is the final one allowed
    assign last_slot = (st_q.rem == LEN_ONE) || (st_q.ptr == CEIL_A);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        clr_d     = 1'b0;

        if (beat.sof && rx_en) begin
            st_d.active = 1'b1;
            st_d.ptr    = start_addr;
            st_d.rem    = buf_len;
            st_d.cnt    = '0;
            st_d.ovr    = 1'b0;
            st_d.bend   = (buf_len == '0) || (start_addr > CEIL_A);
            clr_d       = st_d.bend;
        end else if (st_q.active) begin
            if (beat.ctl) st_d.ctrl = beat.data;

            if (beat.dat) begin
                if (!st_q.bend) begin
                    st_d.we    = 1'b1;
                    st_d.waddr = st_q.ptr;
                    st_d.wdata = beat.data;
                    st_d.rem   = st_q.rem - LEN_ONE;
                    st_d.cnt   = st_q.cnt + LEN_ONE;
                    if (last_slot) begin
                        st_d.bend = 1'b1;
                        clr_d     = 1'b1;
                    end else begin
                        st_d.ptr  = st_q.ptr + PTR_ONE;
                    end
                end else begin
                    st_d.ovr = 1'b1;
                end
            end

            if (beat.eof) begin
                st_d.rxlen  = st_d.cnt;
                st_d.done   = 1'b1;
                st_d.active = 1'b0;
                clr_d       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_clear   = clr_d;
    assign rx_len     = st_q.rxlen;
    assign ctrl_byte  = st_q.ctrl;
    assign remain     = st_q.rem;
    assign buf_end    = st_q.bend;
    assign overrun    = st_q.ovr;
    assign frame_done = st_q.done;
    assign ram_we     = st_q.we;
    assign ram_addr   = st_q.waddr;
    assign ram_wdata  = st_q.wdata;

    // R6
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> (st_q.waddr <= CEIL_A));

    // R4
    remain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> (st_q.rem == $past(st_q.rem) - LEN_ONE));

    // R7
    overrun_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |-> st_q.bend);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

endmodule

// File: rtl/sdlc_rxbuf_dma.sv
module sdlc_rxbuf_dma
    import sdlc_rxbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int ADDR_CEIL = ADDR_CEIL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_start,
    input  logic              cpu_wr_len,
    input  logic              cpu_wr_enable,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              rx_sof,
    input  logic              rx_ctl_vld,
    input  logic              rx_dat_vld,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [LEN_W-1:0]  buf_len_o,
    output logic [LEN_W-1:0]  rx_len_o,
    output logic [BYTE_W-1:0] ctrl_byte_o,
    output logic [LEN_W-1:0]  remain_o,
    output logic              rx_en_o,
    output logic              buf_end_o,
    output logic              overrun_o,
    output logic              frame_done_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [BYTE_W-1:0] ram_wdata_o
);

    rx_beat_t beat;
    logic     en_clear;

    assign beat = '{sof: rx_sof, ctl: rx_ctl_vld, dat: rx_dat_vld,
                    eof: rx_eof, data: rx_byte};

    sdlc_rxbuf_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (BYTE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (cpu_wr_start),
        .wr_len     (cpu_wr_len),
        .wr_enable  (cpu_wr_enable),
        .wdata      (cpu_wdata),
        .en_clear   (en_clear),
        .start_addr (start_addr_o),
        .buf_len    (buf_len_o),
        .rx_en      (rx_en_o)
    );

    sdlc_rxbuf_engine #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .ADDR_CEIL (ADDR_CEIL)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (beat),
        .rx_en      (rx_en_o),
        .start_addr (start_addr_o),
        .buf_len    (buf_len_o),
        .en_clear   (en_clear),
        .rx_len     (rx_len_o),
        .ctrl_byte  (ctrl_byte_o),
        .remain     (remain_o),
        .buf_end    (buf_end_o),
        .overrun    (overrun_o),
        .frame_done (frame_done_o),
        .ram_we     (ram_we_o),
        .ram_addr   (ram_addr_o),
        .ram_wdata  (ram_wdata_o)
    );

    // R5
    end_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_end_o) |-> !rx_en_o);

endmodule

// File: tb/sdlc_rxbuf_dma_test.sv
module sdlc_rxbuf_dma_test;

    localparam int PERIOD = 10;
    localparam int CEIL   = 191;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_start = 0, cpu_wr_len = 0, cpu_wr_enable = 0;
    logic [7:0] cpu_wdata = 0;
    logic       rx_sof = 0, rx_ctl_vld = 0, rx_dat_vld = 0, rx_eof = 0;
    logic [7:0] rx_byte = 0;
    logic [7:0] start_addr_o, buf_len_o, rx_len_o, ctrl_byte_o, remain_o;
    logic       rx_en_o, buf_end_o, overrun_o, frame_done_o, ram_we_o;
    logic [7:0] ram_addr_o, ram_wdata_o;

    int vectors = 0;
    int errors  = 0;
    int max_addr = -1;

    // behavioural reference state
    int m_start, m_len, m_en, m_active, m_ptr, m_rem, m_cnt;
    int m_rxlen, m_ctrl, m_bend, m_ovr, m_done, m_we, m_addr, m_wdata;

    always #(PERIOD/2) clk = ~clk;

    sdlc_rxbuf_dma uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_start(cpu_wr_start), .cpu_wr_len(cpu_wr_len),
        .cpu_wr_enable(cpu_wr_enable), .cpu_wdata(cpu_wdata),
        .rx_sof(rx_sof), .rx_ctl_vld(rx_ctl_vld), .rx_dat_vld(rx_dat_vld),
        .rx_eof(rx_eof), .rx_byte(rx_byte),
        .start_addr_o(start_addr_o), .buf_len_o(buf_len_o),
        .rx_len_o(rx_len_o), .ctrl_byte_o(ctrl_byte_o), .remain_o(remain_o),
        .rx_en_o(rx_en_o), .buf_end_o(buf_end_o), .overrun_o(overrun_o),
        .frame_done_o(frame_done_o), .ram_we_o(ram_we_o),
        .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_start = 0; m_len = 0; m_en = 0; m_active = 0; m_ptr = 0; m_rem = 0;
        m_cnt = 0; m_rxlen = 0; m_ctrl = 0; m_bend = 0; m_ovr = 0; m_done = 0;
        m_we = 0; m_addr = 0; m_wdata = 0;
    endtask

    task automatic model_step();
        int clr = 0;
        m_done = 0;
        m_we = 0;
        if (rx_sof && m_en != 0) begin
            m_active = 1; m_ptr = m_start; m_rem = m_len; m_cnt = 0; m_ovr = 0;
            m_bend = (m_len == 0 || m_start > CEIL) ? 1 : 0;
            if (m_bend != 0) clr = 1;
        end else if (m_active != 0) begin
            if (rx_ctl_vld) m_ctrl = rx_byte;
            if (rx_dat_vld) begin
                if (m_bend == 0) begin
                    m_we = 1; m_addr = m_ptr; m_wdata = rx_byte;
                    m_rem--; m_cnt++;
                    if (m_rem == 0 || m_ptr == CEIL) begin m_bend = 1; clr = 1; end
                    else m_ptr++;
                end else m_ovr = 1;
            end
            if (rx_eof) begin
                m_rxlen = m_cnt; m_done = 1; m_active = 0; clr = 1;
            end
        end
        if (cpu_wr_start && m_en == 0) m_start = cpu_wdata;
        if (cpu_wr_len && m_en == 0)   m_len = cpu_wdata;
        if (cpu_wr_enable)             m_en = cpu_wdata[0];
        if (clr != 0)                  m_en = 0;
    endtask

    task automatic compare_all();
        cmp("R2", "start_addr", start_addr_o, m_start);
        cmp("R2", "buf_len", buf_len_o, m_len);
        cmp("R3", "rx_en", rx_en_o, m_en);
        cmp("R10", "remain", remain_o, m_rem);
        cmp("R5", "buf_end", buf_end_o, m_bend);
        cmp("R7", "overrun", overrun_o, m_ovr);
        cmp("R8", "frame_done", frame_done_o, m_done);
        cmp("R8", "rx_len", rx_len_o, m_rxlen);
        cmp("R9", "ctrl_byte", ctrl_byte_o, m_ctrl);
        cmp("R4", "ram_we", ram_we_o, m_we);
        if (m_we != 0) begin
            cmp("R4", "ram_addr", ram_addr_o, m_addr);
            cmp("R4", "ram_wdata", ram_wdata_o, m_wdata);
        end
        if (ram_we_o && int'(ram_addr_o) > max_addr) max_addr = ram_addr_o;
    endtask

    // one clock: inputs already set, model and design advance, compare off-edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        cpu_wr_start = 0; cpu_wr_len = 0; cpu_wr_enable = 0;
        rx_sof = 0; rx_ctl_vld = 0; rx_dat_vld = 0; rx_eof = 0;
    endtask

    task automatic set_start(input int v); cpu_wr_start = 1; cpu_wdata = 8'(v); tick(); endtask
    task automatic set_len(input int v);   cpu_wr_len = 1;   cpu_wdata = 8'(v); tick(); endtask
    task automatic set_en(input int v);    cpu_wr_enable = 1; cpu_wdata = 8'(v); tick(); endtask
    task automatic sof();                  rx_sof = 1; tick(); endtask
    task automatic ctl(input int b);       rx_ctl_vld = 1; rx_byte = 8'(b); tick(); endtask
    task automatic dat(input int b);       rx_dat_vld = 1; rx_byte = 8'(b); tick(); endtask
    task automatic eof();                  rx_eof = 1; tick(); endtask

    initial begin
        #(PERIOD*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all();
        cmp("R1", "reset flags", {rx_en_o, buf_end_o, overrun_o, frame_done_o, ram_we_o}, 0);
        rst_n = 1;
        tick();

        // R4 R8 R9 normal frame: start 16, length 4, three bytes
        set_start(16); set_len(4); set_en(1);
        sof(); ctl(8'h3A);
        for (int i = 0; i < 3; i++) dat(8'hA0 + i);
        eof();
        cmp("R8", "rx_len after frame", rx_len_o, 3);

        // R2 writes while armed are ignored
        set_en(1); set_len(9); set_start(77);
        cmp("R2", "len frozen", buf_len_o, 4);
        cmp("R2", "start frozen", start_addr_o, 16);
        // R9 control strobe outside a frame is ignored
        ctl(8'h55);
        cmp("R9", "ctrl kept", ctrl_byte_o, 8'h3A);
        set_en(0);
        // R3 frame start while disabled does nothing
        sof(); dat(8'h11);
        cmp("R3", "no write while idle", ram_we_o, 0);

        // R5 R7 length runs out, overrun follows
        set_len(2); set_en(1);
        sof(); ctl(8'h10);
        for (int i = 0; i < 4; i++) dat(8'h20 + i);
        cmp("R7", "overrun set", overrun_o, 1);
        eof();
        cmp("R8", "rx_len capped", rx_len_o, 2);

        // R5 zero length: end at start of frame
        set_len(0); set_en(1);
        sof();
        cmp("R5", "zero length end", buf_end_o, 1);
        dat(8'h99); eof();
        cmp("R8", "zero length rx_len", rx_len_o, 0);

        // R7 next frame clears overrun
        set_len(5); set_en(1); sof();
        cmp("R7", "overrun cleared", overrun_o, 0);
        dat(1); eof();

        // R6 ceiling: start 189, plenty of length
        max_addr = -1;
        set_start(189); set_len(10); set_en(1);
        sof();
        for (int i = 0; i < 6; i++) dat(8'hC0 + i);
        eof();
        cmp("R6", "highest address", max_addr, CEIL);
        cmp("R6", "rx_len at ceiling", rx_len_o, 3);

        // R6 start above ceiling
        max_addr = -1;
        set_start(200); set_len(8); set_en(1);
        sof();
        cmp("R6", "end on bad start", buf_end_o, 1);
        dat(1); dat(2); eof();
        cmp("R6", "no write on bad start", max_addr, -1);

        // mixed frames with varied bytes and lengths
        for (int f = 0; f < 6; f++) begin
            set_start(40 + f * 20); set_len(f + 1); set_en(1);
            sof(); ctl(f * 17);
            for (int i = 0; i < f + 2; i++) dat((f * 31 + i * 7) & 255);
            eof();
            repeat (2) tick();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule